// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz time-base enable into a periodic tick whose rate is picked by a 4-bit rate-select code. On every tick it pulses a strobe that sets the periodic flag. When the periodic interrupt is enabled, it also pulses the strobe that sets the interrupt flag and raises the request. When the square-wave output is enabled, it emits a single-cycle pulse. The surrounding timekeeping logic owns the flag register, so it reads these strobes as set requests.

A free-running 15-bit counter counts the time-base enables. A tick falls on the enable that brings this count to a multiple of the period. Every tick therefore lands on a period boundary, and a change of rate simply waits for the next boundary of the new period. The codes are non-linear. Zero switches the tick off. Codes 1 and 2 are remapped to the slow rates of codes 8 and 9. Every other code N gives a period of 2^(N-1) enables.

A small state machine steps the tick. ST_OFF means the divider is stopped. ST_RUN means it is waiting for a boundary. ST_FIRE is the single cycle in which the strobes are driven. The transitions are:
- halt: any state goes to ST_OFF when the code is zero or both enables are clear.
- arm: ST_OFF goes to ST_RUN when the divider becomes active and no boundary enable arrives.
- fire: any state goes to ST_FIRE when the divider is active and a boundary enable arrives.
- resume: ST_FIRE goes to ST_RUN.

Top module: `periodic_tick_divider`

## Requirements
- R1: After reset all three outputs are low and the enable counter is zero. With code 3 active, the first tick therefore comes on the fourth time-base enable.
- R2: No strobe or pulse is produced while `rate_sel` is 0, or while both `per_irq_en` and `pulse_en` are 0.
- R3: For codes 3 to 15 the tick period is 2^(code-1) time-base enables. For example, code 3 gives 4 enables and code 15 gives 16384 enables.
- R4: Code 1 gives a period of 128 enables and code 2 gives a period of 256 enables.
- R5: A tick fires only on a clock cycle where `base_en` is high and the enable count, after this enable is added, is a multiple of the period. The 15-bit count runs freely and wraps modulo 32768. It keeps counting whatever the code and enables are.
- R6: `per_flag_set` pulses on every tick. `irq_flag_set` pulses on a tick only when `per_irq_en` is 1.
- R7: `sqw_pulse` pulses on a tick only when `pulse_en` is 1. It is a single-cycle pulse, not a 50% duty wave.
- R8: Each strobe is high for exactly the one clock cycle that follows the edge taking the boundary enable, and is low in every other cycle.
- R9: A change of `rate_sel`, `per_irq_en` or `pulse_en` takes effect at the very next edge. Dropping both enables in the boundary cycle suppresses that tick. A new rate ticks at the next boundary of the new period, with no extra tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle enable at 32768 Hz |
| rate_sel | input | 4 | Rate-select code |
| per_irq_en | input | 1 | Periodic interrupt enable |
| pulse_en | input | 1 | Square-wave pulse enable |
| per_flag_set | output | 1 | Periodic-flag set strobe |
| irq_flag_set | output | 1 | Interrupt-flag set strobe and request |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
The bench builds the block with its default 15-bit counter and 4-bit code. This keeps the full code space within reach, including the 16384-enable period of code 15. It also lets the test run the counter through its modulo-32768 wrap, where a boundary coincides with the count returning to zero. Holding `base_en` high on consecutive cycles keeps even the slowest period short. Gapped enables, in turn, show that ticks only ever land on enable cycles.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } tick_state_e;

endpackage

// File: rtl/rate_code_decode.sv
module rate_code_decode #(
    parameter int CODE_W    = 4,
    parameter int SH_W      = 4,
    parameter int REMAP_MAX = 2,
    parameter int REMAP_ADD = 7
) (
    input  logic [CODE_W-1:0] code,
    output logic              code_nz,
    output logic [SH_W-1:0]   shift
);

    logic [CODE_W-1:0] eff_code;

    always_comb begin
        code_nz = (code != '0);
        if (code <= CODE_W'(REMAP_MAX)) begin
            eff_code = code + CODE_W'(REMAP_ADD);
        end else begin
            eff_code = code;
        end
        shift = SH_W'(eff_code) - SH_W'(1);
    end

endmodule

// File: rtl/base_enable_counter.sv
module base_enable_counter #(
    parameter int CNT_W = 15,
    parameter int SH_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_en,
    input  logic [SH_W-1:0] shift,
    output logic            boundary
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] low_mask;

    assign cnt_inc = cnt_q + 1'b1;

    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_mask
            assign low_mask[i] = (shift > SH_W'(i));
        end
    endgenerate

    assign boundary = ((cnt_inc & low_mask) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (base_en) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/tick_fsm.sv
module tick_fsm
    import tick_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic base_en,
    input  logic boundary,
    input  logic active,
    input  logic irq_en,
    input  logic sqw_en,
    output logic flag_set,
    output logic irq_set,
    output logic sqw_out
);

    tick_state_e state_q;
    tick_state_e state_d;
    logic        irq_sel_q;
    logic        sqw_sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!active)                   state_d = ST_OFF;
                else if (base_en && boundary)  state_d = ST_FIRE;
                else                           state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!active)                   state_d = ST_OFF;
                else if (base_en && boundary)  state_d = ST_FIRE;
                else                           state_d = ST_RUN;
            end
            ST_FIRE: begin
                if (!active)                   state_d = ST_OFF;
                else if (base_en && boundary)  state_d = ST_FIRE;
                else                           state_d = ST_RUN;
            end
            default:                           state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sel_q <= 1'b0;
            sqw_sel_q <= 1'b0;
        end else if (state_d == ST_FIRE) begin
            irq_sel_q <= irq_en;
            sqw_sel_q <= sqw_en;
        end
    end

    assign flag_set = (state_q == ST_FIRE);
    assign irq_set  = (state_q == ST_FIRE) && irq_sel_q;
    assign sqw_out  = (state_q == ST_FIRE) && sqw_sel_q;

endmodule

// File: rtl/periodic_tick_divider.sv
module periodic_tick_divider #(
    parameter int CNT_W     = 15,
    parameter int CODE_W    = 4,
    parameter int REMAP_MAX = 2,
    parameter int REMAP_ADD = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              per_irq_en,
    input  logic              pulse_en,
    output logic              per_flag_set,
    output logic              irq_flag_set,
    output logic              sqw_pulse
);

    localparam int SH_W = $clog2(CNT_W + 1);

    logic            code_nz;
    logic [SH_W-1:0] shift;
    logic            boundary;
    logic            active;

    rate_code_decode #(
        .CODE_W    (CODE_W),
        .SH_W      (SH_W),
        .REMAP_MAX (REMAP_MAX),
        .REMAP_ADD (REMAP_ADD)
    ) u_decode (
        .code    (rate_sel),
        .code_nz (code_nz),
        .shift   (shift)
    );

    base_enable_counter #(
        .CNT_W (CNT_W),
        .SH_W  (SH_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_en  (base_en),
        .shift    (shift),
        .boundary (boundary)
    );

    assign active = code_nz && (per_irq_en || pulse_en);

    tick_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_en  (base_en),
        .boundary (boundary),
        .active   (active),
        .irq_en   (per_irq_en),
        .sqw_en   (pulse_en),
        .flag_set (per_flag_set),
        .irq_set  (irq_flag_set),
        .sqw_out  (sqw_pulse)
    );

endmodule

// File: rtl/tick_divider_checker.sv
module tick_divider_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_en,
    input logic [CODE_W-1:0] rate_sel,
    input logic              per_irq_en,
    input logic              pulse_en,
    input logic              per_flag_set,
    input logic              irq_flag_set,
    input logic              sqw_pulse
);

    p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        per_flag_set |-> (($past(rate_sel) != '0) && ($past(per_irq_en) || $past(pulse_en))));

    p_tick_on_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        per_flag_set |-> $past(base_en));

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag_set |-> (per_flag_set && $past(per_irq_en)));

    p_sqw_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |-> (per_flag_set && $past(pulse_en)));

    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_flag_set |=> !per_flag_set);

endmodule

bind periodic_tick_divider tick_divider_checker #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_en      (base_en),
    .rate_sel     (rate_sel),
    .per_irq_en   (per_irq_en),
    .pulse_en     (pulse_en),
    .per_flag_set (per_flag_set),
    .irq_flag_set (irq_flag_set),
    .sqw_pulse    (sqw_pulse)
);

// File: tb/sim_periodic_tick_divider.sv
`timescale 1ns/1ps
module sim_periodic_tick_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       per_irq_en = 1'b0;
    logic       pulse_en = 1'b0;
    logic       per_flag_set;
    logic       irq_flag_set;
    logic       sqw_pulse;

    int checks = 0;
    int errors = 0;
    int ticks_seen = 0;
    int first_tick = -1;
    int enables_given = 0;
    logic [14:0] mcnt = '0;

    always #2.5 clk = ~clk;

    periodic_tick_divider u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_en      (base_en),
        .rate_sel     (rate_sel),
        .per_irq_en   (per_irq_en),
        .pulse_en     (pulse_en),
        .per_flag_set (per_flag_set),
        .irq_flag_set (irq_flag_set),
        .sqw_pulse    (sqw_pulse)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int period_log2(logic [3:0] code);
        if (code == 4'd1) return 7;
        if (code == 4'd2) return 8;
        return int'(code) - 1;
    endfunction

    // One clock cycle, called at a falling edge; compares outputs at the next one.
    task automatic cycle(string tag, bit en);
        logic [14:0] nxt;
        logic [14:0] mask;
        bit fire;
        nxt  = mcnt + 15'd1;
        mask = 15'((32'd1 << period_log2(rate_sel)) - 1);
        fire = (rate_sel != 0) && (per_irq_en || pulse_en) && en && ((nxt & mask) == 0);
        base_en = en;
        if (en) begin
            mcnt = nxt;
            enables_given++;
        end
        @(negedge clk);
        check({tag, " flag"}, int'(per_flag_set), int'(fire));
        check({tag, " irq"},  int'(irq_flag_set), int'(fire && per_irq_en));
        check({tag, " sqw"},  int'(sqw_pulse),    int'(fire && pulse_en));
        if (per_flag_set) begin
            ticks_seen++;
            if (first_tick < 0) first_tick = enables_given;
        end
    endtask

    task automatic run(string tag, int n_en, int gap);
        for (int i = 0; i < n_en; i++) begin
            cycle(tag, 1'b1);
            for (int g = 0; g < gap; g++) cycle(tag, 1'b0);
        end
    endtask

    // Advance until the next enable lands on a boundary of the current period.
    task automatic align_to(string tag, int lg);
        for (int i = 0; i < 40000; i++) begin
            if (((mcnt + 15'd1) & 15'((32'd1 << lg) - 1)) == 0) break;
            cycle(tag, 1'b1);
        end
    endtask

    task automatic t_reset;
        check("R1 flag at reset", int'(per_flag_set), 0);
        check("R1 irq at reset",  int'(irq_flag_set), 0);
        check("R1 sqw at reset",  int'(sqw_pulse), 0);
        rate_sel = 4'd3; per_irq_en = 1'b1;
        ticks_seen = 0; first_tick = -1; enables_given = 0;
        run("R1", 8, 0);
        check("R1 first tick enable index", first_tick, 4);
    endtask

    task automatic t_idle;
        ticks_seen = 0;
        rate_sel = 4'd0; per_irq_en = 1'b1; pulse_en = 1'b1;
        run("R2 code0", 600, 0);
        rate_sel = 4'd4; per_irq_en = 1'b0; pulse_en = 1'b0;
        run("R2 no enables", 64, 0);
        check("R2 idle tick count", ticks_seen, 0);
    endtask

    task automatic t_fast_codes;
        rate_sel = 4'd3; per_irq_en = 1'b1; pulse_en = 1'b0;
        ticks_seen = 0;
        run("R3 code3", 64, 0);
        check("R3 code3 ticks per 64", ticks_seen, 16);
        rate_sel = 4'd6; ticks_seen = 0;
        run("R3 code6", 128, 0);
        check("R3 code6 ticks per 128", ticks_seen, 4);
    endtask

    task automatic t_alias;
        rate_sel = 4'd1; per_irq_en = 1'b1; pulse_en = 1'b0;
        ticks_seen = 0;
        run("R4 code1", 512, 0);
        check("R4 code1 ticks per 512", ticks_seen, 4);
        rate_sel = 4'd2; ticks_seen = 0;
        run("R4 code2", 512, 0);
        check("R4 code2 ticks per 512", ticks_seen, 2);
    endtask

    task automatic t_slowest_wrap;
        rate_sel = 4'd15; per_irq_en = 1'b1; pulse_en = 1'b1;
        ticks_seen = 0;
        run("R3 code15 wrap R5", 32768, 0);
        check("R3 code15 ticks per 32768", ticks_seen, 2);
    endtask

    task automatic t_gapped;
        rate_sel = 4'd3; per_irq_en = 1'b1; pulse_en = 1'b0;
        ticks_seen = 0;
        run("R5 gapped", 24, 2);
        check("R5 gapped ticks per 24 enables", ticks_seen, 6);
    endtask

    task automatic t_flag_gating;
        rate_sel = 4'd4; per_irq_en = 1'b0; pulse_en = 1'b1;
        ticks_seen = 0;
        run("R6 R7 sqw only", 32, 0);
        check("R6 sqw-only flag ticks", ticks_seen, 4);
        per_irq_en = 1'b1; pulse_en = 1'b0;
        align_to("R6", 3);
        cycle("R6 R8 irq tick", 1'b1);
        check("R6 irq on tick", int'(irq_flag_set), 1);
        check("R7 no sqw when disabled", int'(sqw_pulse), 0);
        cycle("R8 after tick", 1'b0);
        check("R8 strobe single cycle", int'(per_flag_set), 0);
    endtask

    task automatic t_live_change;
        rate_sel = 4'd8; per_irq_en = 1'b1; pulse_en = 1'b0;
        run("R9 code8", 50, 0);
        rate_sel = 4'd4; ticks_seen = 0;
        run("R9 switched to code4", 16, 0);
        check("R9 ticks after rate change", ticks_seen, 2);
        align_to("R9", 3);
        per_irq_en = 1'b0;
        cycle("R9 drop on boundary", 1'b1);
        check("R9 dropped tick suppressed", int'(per_flag_set), 0);
        per_irq_en = 1'b1;
        run("R9 re-enabled", 16, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_fast_codes();
        t_alias();
        t_slowest_wrap();
        t_gapped();
        t_flag_gating();
        t_live_change();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule